// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block is a multi-cycle controller for the repeated memory-move and memory-search operations of an 8-bit processor core. A start pulse loads a source pointer, a destination pointer, a 16-bit counter, the accumulator value and the current flag byte. The block then runs one step, or keeps stepping until its stop condition, with the pointers moving up or down. Each step performs byte reads and writes over a simple request/acknowledge memory port. When the block finishes it presents the updated pointers, counter and flag byte and raises `done` for one cycle.

A copy step moves one byte from the source pointer to the destination pointer. A compare step subtracts the byte at the source pointer from the accumulator and keeps only the flags. The flag results follow the block-operation rules. The parity/overflow bit reports whether the counter is still nonzero, and the two undocumented bits come from an intermediate sum or difference.

Every iteration is padded to a fixed cycle budget. An iteration that continues costs 21 cycles and the last one costs 16. At the end of an iteration that would continue, an interrupt-pending input is sampled. If it is high, the block stops and raises a re-execute indication, so the instruction is fetched again after the interrupt has been served.

Top module: `blkxfer_seq`

## Requirements
- R1: A copy step reads the byte at the source pointer and writes it to the destination pointer. Both pointers then move by +1 when `dir_dn`=0, or by −1 (modulo 2^16) when `dir_dn`=1, and the counter decreases by 1 (modulo 2^16).
- R2: The flag byte layout is bit7 S, bit6 Z, bit5 X, bit4 H, bit3 Y, bit2 P/V, bit1 N, bit0 C. After a copy step, H=0 and N=0, P/V = (new counter != 0), and S, Z and C keep their loaded values. A counter loaded as 0 becomes 0xFFFF with P/V=1.
- R3: After a copy step, flag bit5 equals bit 1 and flag bit3 equals bit 3 of (transferred byte + accumulator) mod 256.
- R4: A compare step leaves the destination pointer unchanged and writes nothing to memory. It sets S to bit 7 of (acc − byte), Z to (acc == byte) and H to (acc[3:0] < byte[3:0]). It sets N=1, keeps C, sets P/V to (new counter != 0), moves the source pointer by ±1 and decreases the counter by 1.
- R5: After a compare step, flag bit5 equals bit 1 and flag bit3 equals bit 3 of (acc − byte − H) mod 256, where H is the new half-borrow.
- R6: With `rpt_en`=1, copying continues until the counter reaches 0. Comparing continues until the counter reaches 0 or an iteration finds acc == byte. With `rpt_en`=0 exactly one step is run.
- R7: With a memory that acknowledges one cycle after a request, `done` rises 16 clock edges after the edge that samples `start` for a single iteration. Each iteration that continues adds 21 edges.
- R8: If `irq_pend` is high at the end of an iteration that would continue, the block stops after that 21-cycle iteration and raises `done` together with `reexec`. Otherwise `reexec` is 0 whenever `done` is high.
- R9: `mem_req` stays high with a stable address and direction until `mem_ack`, and it is low in the cycle after the acknowledge.
- R10: After reset the block is idle, with `done`, `busy`, `reexec` and `mem_req` low. A `start` pulse while `busy` is high is ignored, along with the input values that come with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| op_cmp | input | 1 | 0 = copy, 1 = compare |
| dir_dn | input | 1 | 0 = pointers increase, 1 = pointers decrease |
| rpt_en | input | 1 | 1 = repeat until the stop condition |
| src_in | input | 16 | Source pointer loaded at start |
| dst_in | input | 16 | Destination pointer loaded at start |
| cnt_in | input | 16 | Counter loaded at start |
| acc_in | input | 8 | Accumulator value |
| flags_in | input | 8 | Flag byte loaded at start |
| irq_pend | input | 1 | Interrupt pending, sampled at the end of a continuing iteration |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with ack |
| mem_ack | input | 1 | Access acknowledge |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current counter |
| flags_out | output | 8 | Current flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reexec | output | 1 | Instruction must be executed again (valid with done) |

## Verification
Copies are run in both directions with counts of 1, 3, 4 and 5 and with a counter loaded as zero. This separates the increment path from the decrement path and the wrap of the counter from its normal decrement. Compares are run against a byte that misses, one that matches on the first step and one that matches on the third step. These show whether the match stops a repeat only for compare operations and whether the half-borrow feeds the undocumented bits. The loaded flag byte switches S, Z and C between runs, so that bits kept unchanged are told apart from bits that are recomputed. Separate runs raise the interrupt input during a continuing copy and during a compare that ends on its first match, and one run pulses start with different operands while the block is busy.

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int CW       = 16,
  parameter int T_FINAL  = 16,
  parameter int T_REPEAT = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_cmp,
  input  logic          dir_dn,
  input  logic          rpt_en,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [DW-1:0] acc_in,
  input  logic [7:0]    flags_in,
  input  logic          irq_pend,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [CW-1:0] cnt_out,
  output logic [7:0]    flags_out,
  output logic          busy,
  output logic          done,
  output logic          reexec
);
  localparam int TW = $clog2(T_REPEAT + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_GAP, ST_WR, ST_EVAL, ST_PAD} st_t;

  st_t           st;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] acc_q, data_q;
  logic [7:0]    flg_q;
  logic          cmp_q, dn_q, rpt_q, rep_q, done_q, reexec_q;
  logic [TW-1:0] tcnt;

  logic [AW-1:0] step;
  logic [CW-1:0] cnt_nx;
  logic [DW-1:0] diff, nsum;
  logic          hc, hit, cnz, rep_nx, budget_end;
  logic [7:0]    flg_nx;

  assign step   = dn_q ? {AW{1'b1}} : AW'(1);
  assign cnt_nx = cnt_q - CW'(1);
  assign cnz    = cnt_nx != '0;
  assign diff   = acc_q - data_q;
  assign hc     = acc_q[3:0] < data_q[3:0];
  assign hit    = diff == '0;
  assign nsum   = cmp_q ? diff - DW'(hc) : data_q + acc_q;
  assign flg_nx = cmp_q ? {diff[DW-1], hit, nsum[1], hc, nsum[3], cnz, 1'b1, flg_q[0]}
                        : {flg_q[7], flg_q[6], nsum[1], 1'b0, nsum[3], cnz, 1'b0, flg_q[0]};
  assign rep_nx = rpt_q && cnz && !(cmp_q && hit);
  assign budget_end = tcnt >= (rep_q ? TW'(T_REPEAT - 1) : TW'(T_FINAL - 1));

  assign mem_req   = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = st == ST_WR;
  assign mem_addr  = (st == ST_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;

  assign src_out   = src_q;
  assign dst_out   = dst_q;
  assign cnt_out   = cnt_q;
  assign flags_out = flg_q;
  assign busy      = st != ST_IDLE;
  assign done      = done_q;
  assign reexec    = reexec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
      data_q   <= '0;
      flg_q    <= '0;
      cmp_q    <= 1'b0;
      dn_q     <= 1'b0;
      rpt_q    <= 1'b0;
      rep_q    <= 1'b0;
      tcnt     <= '0;
      done_q   <= 1'b0;
      reexec_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      reexec_q <= 1'b0;
      if (st != ST_IDLE && tcnt != TW'(T_REPEAT))
        tcnt <= tcnt + TW'(1);
      case (st)
        ST_IDLE: if (start) begin
          src_q <= src_in;
          dst_q <= dst_in;
          cnt_q <= cnt_in;
          acc_q <= acc_in;
          flg_q <= flags_in;
          cmp_q <= op_cmp;
          dn_q  <= dir_dn;
          rpt_q <= rpt_en;
          rep_q <= 1'b0;
          tcnt  <= '0;
          st    <= ST_RD;
        end
        ST_RD: if (mem_ack) begin
          data_q <= mem_rdata;
          st     <= cmp_q ? ST_EVAL : ST_GAP;
        end
        ST_GAP: st <= ST_WR;
        ST_WR: if (mem_ack) st <= ST_EVAL;
        ST_EVAL: begin
          src_q <= src_q + step;
          if (!cmp_q) dst_q <= dst_q + step;
          cnt_q <= cnt_nx;
          flg_q <= flg_nx;
          rep_q <= rep_nx;
          st    <= ST_PAD;
        end
        ST_PAD: if (budget_end) begin
          if (rep_q && !irq_pend) begin
            tcnt <= '0;
            st   <= ST_RD;
          end else begin
            done_q   <= 1'b1;
            reexec_q <= rep_q;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module blkxfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        reexec,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [15:0] mem_addr,
  input logic [7:0]  flags_out,
  input logic [15:0] cnt_out,
  input logic        cmp_mode
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);
  assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmp_mode |-> !mem_we);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);
  assert_reexec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reexec |-> done && flags_out[2]);
  assert_pv_counter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[2] == (cnt_out != 16'h0000));
  assert_copy_hn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cmp_mode |-> !flags_out[4] && !flags_out[1]);
  assert_cmp_n_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && cmp_mode |-> flags_out[1]);
endmodule

bind blkxfer_seq blkxfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .reexec(reexec),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .flags_out(flags_out), .cnt_out(cnt_out), .cmp_mode(cmp_q)
);

// File: tb/blkxfer_seq_bench.sv
module blkxfer_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, op_cmp = 1'b0, dir_dn = 1'b0, rpt_en = 1'b0, irq_pend = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic [7:0]  acc_in = '0, flags_in = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic [15:0] src_out, dst_out, cnt_out;
  logic [7:0]  flags_out;
  logic        busy, done, reexec;

  blkxfer_seq u_blkxfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_cmp(op_cmp), .dir_dn(dir_dn), .rpt_en(rpt_en),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .acc_in(acc_in), .flags_in(flags_in),
    .irq_pend(irq_pend), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out), .flags_out(flags_out),
    .busy(busy), .done(done), .reexec(reexec)
  );

  int nchk = 0, nbad = 0, ncyc = 0, wr_cnt = 0, hs_viol = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] ref_mem [0:1023];
  logic prev_req = 1'b0, prev_ack = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(posedge clk) begin
    prev_req <= mem_req;
    prev_ack <= mem_ack;
    if (rst_n && prev_req && !prev_ack && !mem_req) hs_viol <= hs_viol + 1;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else mem_rdata <= mem[mem_addr[9:0]];
    end else mem_ack <= 1'b0;
  end

  typedef struct {
    logic [15:0] s, d, c;
    logic [7:0]  f;
    logic        rx;
    int          lat, t0;
    string       nm;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (sb.size() == 0) chk("R10 unexpected done", 1, 0);
      else begin
        e = sb.pop_front();
        chk({e.nm, " R1 src"}, src_out, e.s);
        chk({e.nm, " R1 dst"}, dst_out, e.d);
        chk({e.nm, " R6 cnt"}, cnt_out, e.c);
        chk({e.nm, " R2/R3/R4/R5 flags"}, flags_out, e.f);
        chk({e.nm, " R8 reexec"}, reexec, e.rx);
        chk({e.nm, " R7 latency"}, ncyc - e.t0 - 1, e.lat);
      end
    end
  end

  task automatic run_op(input string nm, input bit op, input bit dn, input bit rp,
                        input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                        input logic [7:0] a, input logic [7:0] f, input bit irq, input bit poke);
    exp_t e;
    logic [15:0] stp, es, ed, ec;
    logic [7:0] ef, b, n, df;
    bit h, rep, rx;
    int iters, wc0, bad;
    stp = dn ? 16'hFFFF : 16'h0001;
    es = s; ed = d; ec = c; ef = f; iters = 0; rx = 1'b0;
    do begin
      b = ref_mem[es[9:0]];
      ec = ec - 16'h0001;
      if (!op) begin
        ref_mem[ed[9:0]] = b;
        n = b + a;
        ef = {ef[7], ef[6], n[1], 1'b0, n[3], ec != 0, 1'b0, ef[0]};
        ed = ed + stp;
        h = 1'b0;
      end else begin
        df = a - b;
        h = a[3:0] < b[3:0];
        n = df - 8'(h);
        ef = {df[7], df == 0, n[1], h, n[3], ec != 0, 1'b1, ef[0]};
      end
      es = es + stp;
      iters++;
      rep = rp && ec != 0 && !(op && a == b);
      if (rep && irq) begin rx = 1'b1; rep = 1'b0; end
    end while (rep);
    e.s = es; e.d = ed; e.c = ec; e.f = ef; e.rx = rx; e.nm = nm;
    e.lat = rx ? 21 * iters : 21 * (iters - 1) + 16;
    @(negedge clk);
    op_cmp = op; dir_dn = dn; rpt_en = rp; src_in = s; dst_in = d; cnt_in = c;
    acc_in = a; flags_in = f; irq_pend = irq; start = 1'b1;
    wc0 = wr_cnt;
    e.t0 = ncyc;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; op_cmp = ~op; src_in = 16'h0300; dst_in = 16'h0310; cnt_in = 16'd9; acc_in = 8'h00;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    irq_pend = 1'b0;
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk({nm, " R1 memory image"}, bad, 0);
    chk({nm, op ? " R4 write count" : " R1 write count"}, wr_cnt - wc0, op ? 0 : iters);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 1'b0;
    fork
      begin
        repeat (200000) @(posedge clk);
        wd_hit = 1'b1;
      end
      begin
        for (int i = 0; i < 1024; i++) begin mem[i] = pat(i); ref_mem[i] = pat(i); end
        repeat (3) @(negedge clk);
        chk("R10 reset done", done, 0);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset req", mem_req, 0);
        chk("R10 reset reexec", reexec, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op("copy1 inc",   0, 0, 0, 16'h0010, 16'h0200, 16'd1, 8'h3C, 8'h00, 0, 0);
        run_op("copy1 dec",   0, 1, 0, 16'h0020, 16'h0210, 16'd5, 8'h05, 8'hC1, 0, 0);
        run_op("copy cnt0",   0, 0, 0, 16'h0000, 16'h03FF, 16'd0, 8'hF7, 8'h40, 0, 0);
        run_op("copyr inc",   0, 0, 1, 16'h0030, 16'h0220, 16'd4, 8'h81, 8'h81, 0, 0);
        run_op("copyr dec",   0, 1, 1, 16'h0038, 16'h0238, 16'd3, 8'h12, 8'h00, 0, 0);
        run_op("cmp1 miss",   1, 0, 0, 16'h0050, 16'h0000, 16'd7, 8'h01, 8'h01, 0, 0);
        run_op("cmp1 hit",    1, 1, 0, 16'h0051, 16'h0000, 16'd1, pat(16'h51), 8'h80, 0, 0);
        run_op("cmpr hit3",   1, 0, 1, 16'h0040, 16'h1234, 16'd6, pat(16'h42), 8'h00, 0, 0);
        run_op("cmpr miss",   1, 1, 1, 16'h0060, 16'h0000, 16'd4, 8'h00, 8'hC1, 0, 0);
        run_op("copyr irq",   0, 0, 1, 16'h0070, 16'h0270, 16'd4, 8'h44, 8'h01, 1, 0);
        run_op("cmpr irq hit",1, 0, 1, 16'h0080, 16'h0000, 16'd5, pat(16'h80), 8'h00, 1, 0);
        run_op("copyr poke",  0, 0, 1, 16'h0090, 16'h0290, 16'd2, 8'h99, 8'h00, 0, 1);
        repeat (3) @(negedge clk);
        chk("R10 no stray result", sb.size(), 0);
        chk("R9 handshake", hs_viol, 0);
      end
    join_any
    if (wd_hit) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule